// File: doc/BRIEF.md
# Bidirectional Latch-or-Register Bus Transceiver

This block joins two 18-bit bidirectional buses, called port A and port B, through two independent one-way paths. One path carries data from A to B and the other from B to A. Each path has one storage element per bit. While that path's latch-open input is high, the element is transparent and the destination follows the source within the same cycle. While the latch-open input is low, the element behaves as a register. It loads the source only when the path's capture clock rises, and otherwise holds its value.

Each path drives the opposite port only while its output enable is asserted, and leaves that port at high impedance otherwise. The enable for the A-to-B path is active high. The enable for the B-to-A path is active low.

The external capture clocks are not used as clocks. A free-running system clock samples them, and a rising edge counts as seen when a system clock edge finds the capture clock high after it was low at the previous edge. The storage has no reset. It is loaded by opening the latch once.

Top module: `bus_xcvr`

## Requirements
- R1: Port B is driven only while `abOe` is 1. While `abOe` is 0, port B is high impedance, whatever the A-to-B latch, clock and data inputs are doing.
- R2: Port A is driven only while `baOeN` is 0. While `baOeN` is 1, port A is high impedance, whatever the B-to-A latch, clock and data inputs are doing.
- R3: While `abLe` is 1 and `abOe` is 1, port B equals port A in the same cycle, with no register in the path.
- R4: While `abLe` is 0, a system clock edge that samples `abClk` as 1, where the previous edge sampled it as 0, stores port A as it stands at that edge. Port B shows the stored value from that edge onward. This also holds when the edge falls in the first cycle after `abLe` drops.
- R5: While `abLe` is 0 and `abClk` stays at 0 or stays at 1, port B keeps the stored value however port A changes.
- R6: If `abLe` falls while `abClk` is already 1, no capture occurs. Port B holds the port A value from the last system clock edge at which `abLe` was 1, until `abClk` goes low and then rises again.
- R7: A rise of `abClk` while `abLe` is 1 has no effect of its own. After the latch closes, port B shows the last transparent value.
- R8: The B-to-A path follows R3 to R7 with `baLe`, `baClk`, port B as source and port A as destination. The controls of one path never change the state or output of the other path.
- R9: The stored value survives output disable. When the output enable is asserted again, the port shows the value held before the disable.
- R10: Reset clears the capture clock samplers to the "was high" state, so a capture clock held at 1 coming out of reset is not a rising edge. With both enables inactive, both ports float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock that samples the capture clocks and updates the storage |
| rstN | input | 1 | Active-low asynchronous reset of the edge samplers only |
| portA | inout | 18 | Bus A: source of the A-to-B path, destination of the B-to-A path |
| portB | inout | 18 | Bus B: source of the B-to-A path, destination of the A-to-B path |
| abOe | input | 1 | A-to-B output enable, active high |
| abLe | input | 1 | A-to-B latch open (1 = transparent) |
| abClk | input | 1 | A-to-B capture clock; its rises load the storage while the latch is closed |
| baOeN | input | 1 | B-to-A output enable, active low |
| baLe | input | 1 | B-to-A latch open (1 = transparent) |
| baClk | input | 1 | B-to-A capture clock |

## Verification
Closing the latch and a rising capture clock can land in the same system clock cycle. The bench provokes this by dropping `abLe` and raising `abClk` in one drive step, after a transparent cycle that shows a different value. The behavioural model then expects the data present at that edge to be stored, not the earlier transparent value. A second collision comes from closing the latch while the clock is already high. Here the bench expects the pre-close value to hold across several cycles and one new source value, and a capture only after the clock has gone low and risen again.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // strobes from a direction's control to its datapath
  typedef struct packed {
    logic loadNow;  // storage takes the source at this system clock edge
    logic bypass;   // destination shows the source directly
    logic driveOn;  // destination port is driven
  } pathStrb_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl #(
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                latchOpen,
  input  logic                capClk,
  input  logic                oeIn,
  output xcvr_pkg::pathStrb_t strb
);
  logic clkSeen;
  logic clkRose;
  logic oeOn;

  // previous sample of the capture clock; reset as "high" so no spurious rise
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) clkSeen <= 1'b1;
    else       clkSeen <= capClk;
  end

  assign clkRose = capClk & ~clkSeen;

  generate
    if (OE_ACTIVE_LOW) begin : gOeLow
      assign oeOn = ~oeIn;
    end else begin : gOeHigh
      assign oeOn = oeIn;
    end
  endgenerate

  always_comb begin
    strb.loadNow = latchOpen | clkRose;
    strb.bypass  = latchOpen;
    strb.driveOn = oeOn;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int WIDTH = 18
) (
  input  logic                sysClk,
  input  xcvr_pkg::pathStrb_t strb,
  input  logic [WIDTH-1:0]    srcBus,
  output logic [WIDTH-1:0]    destVal,
  output logic                destOn
);
  logic [WIDTH-1:0] held;

  // storage without reset: loaded by opening the latch
  always_ff @(posedge sysClk) begin
    if (strb.loadNow) held <= srcBus;
  end

  assign destVal = strb.bypass ? srcBus : held;
  assign destOn  = strb.driveOn;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             sysClk,
  input  logic             rstN,
  inout  wire [WIDTH-1:0]  portA,
  inout  wire [WIDTH-1:0]  portB,
  input  logic             abOe,
  input  logic             abLe,
  input  logic             abClk,
  input  logic             baOeN,
  input  logic             baLe,
  input  logic             baClk
);
  xcvr_pkg::pathStrb_t abStrb, baStrb;
  logic [WIDTH-1:0] abVal, baVal;
  logic abOn, baOn;

  xcvr_ctrl #(.OE_ACTIVE_LOW(1'b0)) u_abCtrl (
    .sysClk(sysClk), .rstN(rstN), .latchOpen(abLe), .capClk(abClk),
    .oeIn(abOe), .strb(abStrb)
  );

  xcvr_ctrl #(.OE_ACTIVE_LOW(1'b1)) u_baCtrl (
    .sysClk(sysClk), .rstN(rstN), .latchOpen(baLe), .capClk(baClk),
    .oeIn(baOeN), .strb(baStrb)
  );

  xcvr_path #(.WIDTH(WIDTH)) u_abPath (
    .sysClk(sysClk), .strb(abStrb), .srcBus(portA),
    .destVal(abVal), .destOn(abOn)
  );

  xcvr_path #(.WIDTH(WIDTH)) u_baPath (
    .sysClk(sysClk), .strb(baStrb), .srcBus(portB),
    .destVal(baVal), .destOn(baOn)
  );

  assign portB = abOn ? abVal : {WIDTH{1'bz}};
  assign portA = baOn ? baVal : {WIDTH{1'bz}};
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 18
) (
  input logic         sysClk,
  input logic         rstN,
  input logic [W-1:0] portA,
  input logic [W-1:0] portB,
  input logic         abOe,
  input logic         abLe,
  input logic         abClk,
  input logic         baOeN,
  input logic         baLe,
  input logic         baClk
);
  // R3
  ab_transparent_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (abLe && abOe) |-> (portB == portA));

  // R4
  ab_capture_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (!abLe && abClk && !$past(abClk)) |=> (abLe || !abOe || portB == $past(portA)));

  // R5
  ab_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (!abLe && $past(!abLe) && abOe && $past(abOe) &&
     !($past(abClk) && !$past(abClk, 2))) |-> $stable(portB));

  // R8
  ba_transparent_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (baLe && !baOeN) |-> (portA == portB));

  // R8
  ba_capture_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (!baLe && baClk && !$past(baClk)) |=> (baLe || baOeN || portA == $past(portB)));
endmodule

bind bus_xcvr xcvr_chk #(.W(WIDTH)) u_chk (.*);

// File: tb/bus_xcvr_tb.sv
`timescale 1ns/1ps
module bus_xcvr_tb;
  localparam int W = 18;

  logic sysClk = 1'b0;
  logic rstN = 1'b0;
  logic abOe = 1'b0, abLe = 1'b0, abClk = 1'b0;
  logic baOeN = 1'b1, baLe = 1'b0, baClk = 1'b0;
  logic drvA = 1'b0, drvB = 1'b0;
  logic [W-1:0] aDrv = '0, bDrv = '0;
  wire  [W-1:0] portA, portB;

  int nCmp = 0;
  int nBad = 0;

  assign portA = drvA ? aDrv : {W{1'bz}};
  assign portB = drvB ? bDrv : {W{1'bz}};

  always #2.5 sysClk = ~sysClk;

  bus_xcvr #(.WIDTH(W)) u_dut (
    .sysClk(sysClk), .rstN(rstN), .portA(portA), .portB(portB),
    .abOe(abOe), .abLe(abLe), .abClk(abClk),
    .baOeN(baOeN), .baLe(baLe), .baClk(baClk)
  );

  // behavioural reference: remembered words and last seen clock levels
  logic [W-1:0] memAB, memBA;
  logic lastAb, lastBa;
  logic [W-1:0] expA, expB;
  logic zA, zB;

  always_comb begin
    zA   = !drvA && baOeN;
    expA = drvA ? aDrv : (baLe ? bDrv : memBA);
    zB   = !drvB && !abOe;
    expB = drvB ? bDrv : (abLe ? expA : memAB);
  end

  always @(posedge sysClk) begin
    if (!rstN) begin
      lastAb <= 1'b1;
      lastBa <= 1'b1;
    end else begin
      if (abLe || (abClk && !lastAb)) memAB <= expA;
      if (baLe || (baClk && !lastBa)) memBA <= expB;
      lastAb <= abClk;
      lastBa <= baClk;
    end
  end

  task automatic cmpPort(input string req, input string nm,
                         input logic [W-1:0] got, input logic [W-1:0] exp,
                         input logic expZ);
    logic bad;
    nCmp++;
    if (expZ) begin
      bad = 1'b0;
      for (int i = 0; i < W; i++) if (got[i] === 1'b1) bad = 1'b1;
    end else begin
      bad = (got !== exp);
    end
    if (bad) begin
      nBad++;
      if (expZ) $display("FAIL %s port %s: got %h expected high impedance", req, nm, got);
      else      $display("FAIL %s port %s: got %h expected %h", req, nm, got, exp);
    end
  endtask

  task automatic tick(input string req);
    @(posedge sysClk);
    @(negedge sysClk);
    cmpPort(req, "A", portA, expA, zA);
    cmpPort(req, "B", portB, expB, zB);
    nCmp++;
    if ((abOe && drvB) || (!baOeN && drvA)) begin
      nBad++;
      $display("FAIL %s contention: got abOe=%b drvB=%b baOeN=%b drvA=%b expected no double drive",
               req, abOe, drvB, baOeN, drvA);
    end
  endtask

  initial begin
    repeat (100000) @(posedge sysClk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge sysClk);
    rstN = 1'b1;
    tick("R10");                                   // both ports float after reset
    // load storage through the open latches
    drvA = 1; aDrv = 18'h2AAAA; drvB = 1; bDrv = 18'h15555;
    abLe = 1; baLe = 1; tick("R3");
    abLe = 0; baLe = 0;
    // A-to-B transparent
    drvB = 0; abOe = 1; abLe = 1; aDrv = 18'h3FFFF; tick("R3");
    aDrv = 18'h01234; tick("R3");
    aDrv = 18'h0BEEF; tick("R3");
    abOe = 0; aDrv = 18'h3FFFF; tick("R1");        // would drive ones, must float
    abOe = 1; tick("R3");
    // hold with clock low
    abLe = 0; aDrv = 18'h00F0F; tick("R5");
    aDrv = 18'h12345; tick("R5");
    abClk = 1; tick("R4");
    aDrv = 18'h2F00D; tick("R5");
    abClk = 0; tick("R5");
    aDrv = 18'h0C0DE; abClk = 1; tick("R4");
    // latch closes while clock already high
    abLe = 1; aDrv = 18'h11111; tick("R3");
    abLe = 0; aDrv = 18'h22222; tick("R6");
    aDrv = 18'h33333; tick("R6");
    abClk = 0; tick("R6");
    abClk = 1; tick("R4");
    // close and rise in the same cycle
    abClk = 0; tick("R5");
    abLe = 1; aDrv = 18'h04444; tick("R3");
    abLe = 0; abClk = 1; aDrv = 18'h05555; tick("R4");
    // rise while transparent
    abClk = 0; abLe = 1; aDrv = 18'h06666; tick("R7");
    abClk = 1; aDrv = 18'h07777; tick("R7");
    abLe = 0; aDrv = 18'h08888; tick("R7");
    abClk = 0; tick("R7");
    // storage survives disable
    abLe = 1; aDrv = 18'h3FFFF; tick("R3");
    abLe = 0; aDrv = 18'h00000; tick("R5");
    abOe = 0; tick("R1");
    abOe = 1; tick("R9");
    // B-to-A path
    abOe = 0; drvA = 0; drvB = 1; baOeN = 0; baLe = 1; bDrv = 18'h3FFFF; tick("R8");
    bDrv = 18'h0ABCD; tick("R8");
    bDrv = 18'h3FFFF; baOeN = 1; tick("R2");      // would drive ones, must float
    baOeN = 0; tick("R8");
    baLe = 0; bDrv = 18'h00000; tick("R8");
    baClk = 1; bDrv = 18'h01357; tick("R8");
    bDrv = 18'h02468; tick("R8");
    baLe = 1; bDrv = 18'h09999; tick("R8");
    baLe = 0; bDrv = 18'h0AAAA; tick("R8");       // closed with clock high
    // A-to-B controls leave B-to-A untouched; A-to-B captures the A bus
    abClk = 1; bDrv = 18'h0F0F0; tick("R8");
    abClk = 0; tick("R8");
    baOeN = 1; drvB = 0; abOe = 1; tick("R8");
    abOe = 0; tick("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule